// File: doc/BRIEF.md
# Ethernet TX clock generator

The block derives the transmit clock for a gigabit-capable MAC from one of two reference sources. It picks a source and divides it by a programmable integer. A fixed divide-by-two stage then sets a 50% duty cycle, and an enable gate follows. Last, the gated clock is shifted in phase by a programmable number of steps. A second output carries the undelayed divided clock toward the PHY, under its own enable bit.

All clocks are modelled synchronously inside one fast system clock `clk_i`. A reference source is a stream of one-cycle enable pulses, where each pulse stands for one source edge. The divided clock and both outputs are registered levels. The phase step is one system clock cycle. When the output runs at a quarter of the system rate, one step is a quarter of the output period. Software programs the block through a single masked write port into a configuration image. Only the bits listed below are stored; the other bits of the image are dropped.

A change to the source select or to the divider field does not take effect at once. It is held until the divided clock is low, so a high phase in progress always finishes at its old length.

Top module: `eth_txclk_gen`

## Requirements
- R1: A write with `cfg_we_i` high replaces each configuration bit whose `cfg_wmask_i` bit is 1 with the bit from `cfg_wdata_i`, and leaves every bit whose mask bit is 0 unchanged. After reset the delay field (bits 6:5) is 1 and every other field is 0, so both outputs stay low.
- R2: Bit 4 selects the source: 0 takes `ref0_i` and 1 takes `ref1_i`.
- R3: For a divider field (bits 9:7) value N from 2 to 7, each high phase and each low phase of the divided clock lasts N pulses of the selected source.
- R4: Divider field values 0 and 1 are accepted as pass-through, so each phase lasts one source pulse.
- R5: The divided clock has equal high and low phases.
- R6: With bit 10 at 0, `tx_clk_o` is low from four cycles after the change onward. With bit 10 at 1, `tx_clk_o` carries the divided clock.
- R7: With bits 10 and 12 both set, `tx_clk_o` lags `phy_ref_o` by D system cycles, where D is the value of bits 6:5 (0 to 3). With a delay of 0 the two outputs are identical.
- R8: With bit 12 at 1, `phy_ref_o` carries the divided clock one cycle late, independent of bit 10. With bit 12 at 0, `phy_ref_o` is low from the next cycle.
- R9: A change to the select or divider field is applied only while the divided clock is low. A high phase already in progress keeps its old length.
- R10: Asserting `rst_ni` low drives both outputs low at once and clears the divider and divide-by-two state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref0_i | input | 1 | Edge pulses of the first reference source |
| ref1_i | input | 1 | Edge pulses of the second reference source |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_wmask_i | input | 32 | Per-bit write mask, 1 = update |
| tx_clk_o | output | 1 | Gated, delayed transmit clock |
| phy_ref_o | output | 1 | Undelayed reference clock toward the PHY |

## Verification
Ten source and divider combinations are run. They include both sources at different pulse spacings, so a swapped select shows up as a wrong phase length. They also cover every divider value from 0 to 7, so pass-through and the divider ratios can be told apart. Each phase is checked for both high and low length.

The phase offset against `phy_ref_o` is measured for each delay setting, including the value left by reset. Writes that set all ones under a narrow mask show whether bits outside the mask are kept. Each enable is turned off while the other output still toggles, to show that the two enables act apart. A divider change made in the middle of a high phase checks that the old phase length is kept. A reset applied while the clocks run checks that both outputs drop at once.

// File: rtl/eth_txclk_pkg.sv
package eth_txclk_pkg;
  localparam int unsigned CFG_W = 32;
  localparam int unsigned DIV_W = 3;
  localparam int unsigned DLY_W = 2;

  // bit positions inside the configuration image
  localparam int unsigned SEL_BIT  = 4;
  localparam int unsigned DLY_LSB  = 5;
  localparam int unsigned DIV_LSB  = 7;
  localparam int unsigned GATE_BIT = 10;
  localparam int unsigned PHY_BIT  = 12;

  typedef struct packed {
    logic             phy_en;
    logic             gate_en;
    logic [DIV_W-1:0] div;
    logic [DLY_W-1:0] dly;
    logic             sel;
  } txclk_cfg_t;

  localparam txclk_cfg_t CFG_RST = '{
    phy_en:  1'b0,
    gate_en: 1'b0,
    div:     '0,
    dly:     DLY_W'(1),
    sel:     1'b0
  };
endpackage

// File: rtl/txclk_cfg_reg.sv
module txclk_cfg_reg
  import eth_txclk_pkg::*;
#(
  parameter int unsigned W = CFG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] wmask_i,
  output txclk_cfg_t   cfg_o
);
  txclk_cfg_t   cfg_q;
  logic [W-1:0] cur_img, nxt_img;
  logic         unused_img;

  always_comb begin
    cur_img                    = '0;
    cur_img[SEL_BIT]           = cfg_q.sel;
    cur_img[DLY_LSB +: DLY_W]  = cfg_q.dly;
    cur_img[DIV_LSB +: DIV_W]  = cfg_q.div;
    cur_img[GATE_BIT]          = cfg_q.gate_en;
    cur_img[PHY_BIT]           = cfg_q.phy_en;
    nxt_img = (cur_img & ~wmask_i) | (wdata_i & wmask_i);
  end

  // bits without a field are dropped
  assign unused_img = ^{nxt_img[W-1:PHY_BIT+1], nxt_img[GATE_BIT+1],
                        nxt_img[SEL_BIT-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
    end else if (we_i) begin
      cfg_q.sel     <= nxt_img[SEL_BIT];
      cfg_q.dly     <= nxt_img[DLY_LSB +: DLY_W];
      cfg_q.div     <= nxt_img[DIV_LSB +: DIV_W];
      cfg_q.gate_en <= nxt_img[GATE_BIT];
      cfg_q.phy_en  <= nxt_img[PHY_BIT];
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/txclk_div.sv
module txclk_div #(
  parameter int unsigned DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref0_i,
  input  logic             ref1_i,
  input  logic             sel_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             clk_o
);
  logic             act_sel_q;
  logic [DIV_W-1:0] act_div_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] term;
  logic             half_q;
  logic             src;
  logic             pend;

  assign src  = act_sel_q ? ref1_i : ref0_i;
  // field values 0 and 1 pass the source through
  assign term = (act_div_q < DIV_W'(2)) ? '0 : act_div_q - DIV_W'(1);
  assign pend = (sel_i != act_sel_q) || (div_i != act_div_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_sel_q <= 1'b0;
      act_div_q <= '0;
      cnt_q     <= '0;
      half_q    <= 1'b0;
    end else if (pend && !half_q) begin
      // adopt new select/ratio only in the low phase
      act_sel_q <= sel_i;
      act_div_q <= div_i;
      cnt_q     <= '0;
    end else if (src) begin
      if (cnt_q == term) begin
        cnt_q  <= '0;
        half_q <= ~half_q;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign clk_o = half_q;
endmodule

// File: rtl/txclk_dly.sv
module txclk_dly #(
  parameter int unsigned TAP_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             d_i,
  input  logic             en_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic             q_o
);
  localparam int unsigned STAGES = 1 << TAP_W;

  logic [STAGES-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= '0;
    else         line_q <= {line_q[STAGES-2:0], d_i & en_i};
  end

  assign q_o = line_q[tap_i];
endmodule

// File: rtl/eth_txclk_gen.sv
module eth_txclk_gen
  import eth_txclk_pkg::*;
#(
  parameter int unsigned W = CFG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ref0_i,
  input  logic         ref1_i,
  input  logic         cfg_we_i,
  input  logic [W-1:0] cfg_wdata_i,
  input  logic [W-1:0] cfg_wmask_i,
  output logic         tx_clk_o,
  output logic         phy_ref_o
);
  txclk_cfg_t cfg;
  logic       div_clk;
  logic       phy_q;

  txclk_cfg_reg #(.W(W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .wmask_i (cfg_wmask_i),
    .cfg_o   (cfg)
  );

  txclk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ref0_i (ref0_i),
    .ref1_i (ref1_i),
    .sel_i  (cfg.sel),
    .div_i  (cfg.div),
    .clk_o  (div_clk)
  );

  txclk_dly #(.TAP_W(DLY_W)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (div_clk),
    .en_i   (cfg.gate_en),
    .tap_i  (cfg.dly),
    .q_o    (tx_clk_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phy_q <= 1'b0;
    else         phy_q <= div_clk & cfg.phy_en;
  end

  assign phy_ref_o = phy_q;
endmodule

// File: rtl/eth_txclk_chk.sv
module eth_txclk_chk
  import eth_txclk_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             half_i,
  input logic             gate_i,
  input logic             phy_en_i,
  input logic [DLY_W-1:0] dly_i,
  input logic             act_sel_i,
  input logic [DIV_W-1:0] act_div_i,
  input logic             tx_i,
  input logic             phy_i
);
  logic [2:0] off_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  off_cnt_q <= '0;
    else if (gate_i)              off_cnt_q <= '0;
    else if (off_cnt_q != 3'd7)   off_cnt_q <= off_cnt_q + 3'd1;
  end

  // R6
  tx_gate_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_cnt_q >= 3'd4) |-> !tx_i);

  // R8
  phy_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(phy_en_i) |-> !phy_i);

  // R8
  phy_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(phy_en_i) |-> (phy_i == $past(half_i)));

  // R9
  act_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((act_sel_i != $past(act_sel_i)) || (act_div_i != $past(act_div_i)))
      |-> (!half_i && !$past(half_i)));

  // R7
  tx_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dly_i == '0) && $past(gate_i) && $past(phy_en_i)) |-> (tx_i == phy_i));
endmodule

bind eth_txclk_gen eth_txclk_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .half_i    (div_clk),
  .gate_i    (cfg.gate_en),
  .phy_en_i  (cfg.phy_en),
  .dly_i     (cfg.dly),
  .act_sel_i (u_div.act_sel_q),
  .act_div_i (u_div.act_div_q),
  .tx_i      (tx_clk_o),
  .phy_i     (phy_ref_o)
);

// File: tb/eth_txclk_gen_tb_top.sv
module eth_txclk_gen_tb_top;
  localparam logic [31:0] M_SEL  = 32'h0000_0010;
  localparam logic [31:0] M_DLY  = 32'h0000_0060;
  localparam logic [31:0] M_DIV  = 32'h0000_0380;
  localparam logic [31:0] M_GATE = 32'h0000_0400;
  localparam logic [31:0] M_PHY  = 32'h0000_1000;
  localparam logic [31:0] M_ALL  = 32'hFFFF_FFFF;
  localparam int GUARD = 3000;

  // p0, p1, sel, div, expected phase length in cycles
  localparam int VEC [10][5] = '{
    '{1, 3, 0, 0,  1},
    '{1, 3, 0, 1,  1},
    '{1, 3, 0, 2,  2},
    '{1, 3, 1, 2,  6},
    '{2, 3, 0, 5, 10},
    '{1, 2, 1, 7, 14},
    '{1, 3, 1, 0,  3},
    '{3, 1, 0, 3,  9},
    '{1, 1, 0, 6,  6},
    '{2, 1, 1, 4,  4}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ref0 = 1'b0, ref1 = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_wmask = '0;
  logic        tx_clk, phy_ref;

  int p0 = 0, p1 = 0, c0 = 0, c1 = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  eth_txclk_gen dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .ref0_i      (ref0),
    .ref1_i      (ref1),
    .cfg_we_i    (cfg_we),
    .cfg_wdata_i (cfg_wdata),
    .cfg_wmask_i (cfg_wmask),
    .tx_clk_o    (tx_clk),
    .phy_ref_o   (phy_ref)
  );

  // source pulse generator, one pulse every p cycles
  initial begin
    forever begin
      @(negedge clk);
      ref0 = (p0 != 0) && (c0 == 0);
      ref1 = (p1 != 0) && (c1 == 0);
      c0 = (c0 + 1 >= p0) ? 0 : c0 + 1;
      c1 = (c1 + 1 >= p1) ? 0 : c1 + 1;
    end
  end

  function automatic logic [31:0] cfg_word(int sel, int div, int dly, int gate, int phy);
    return (32'(sel) << 4) | (32'(dly) << 5) | (32'(div) << 7) |
           (32'(gate) << 10) | (32'(phy) << 12);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(logic [31:0] data, logic [31:0] mask);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = data; cfg_wmask = mask;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic measure(output int hi, output int lo);
    int guard = 0;
    hi = 0; lo = 0;
    while (tx_clk !== 1'b0 && guard < GUARD) begin @(negedge clk); guard++; end
    while (tx_clk !== 1'b1 && guard < GUARD) begin @(negedge clk); guard++; end
    while (tx_clk === 1'b1 && guard < GUARD) begin hi++; @(negedge clk); guard++; end
    while (tx_clk === 1'b0 && guard < GUARD) begin lo++; @(negedge clk); guard++; end
  endtask

  task automatic measure_phase(output int n);
    int guard = 0;
    n = 0;
    while (phy_ref !== 1'b1 && guard < GUARD) begin @(negedge clk); guard++; end
    while (phy_ref !== 1'b0 && guard < GUARD) begin @(negedge clk); guard++; end
    while (phy_ref !== 1'b1 && guard < GUARD) begin @(negedge clk); guard++; end
    while (tx_clk !== 1'b1 && guard < GUARD) begin n++; @(negedge clk); guard++; end
  endtask

  task automatic count_highs(int cycles, output int ntx, output int nphy);
    ntx = 0; nphy = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (tx_clk === 1'b1) ntx++;
      if (phy_ref === 1'b1) nphy++;
    end
  endtask

  initial begin
    int hi, lo, ph, ntx, nphy, guard;
    string tag;

    // R10: outputs low during reset with a running source
    p0 = 1; p1 = 3;
    repeat (6) @(negedge clk);
    check("R10 tx in reset", int'(tx_clk), 0);
    check("R10 phy in reset", int'(phy_ref), 0);
    rst_ni = 1'b1;
    repeat (20) @(negedge clk);
    // R1: reset leaves both enables off
    check("R1 reset outputs low", int'(tx_clk) + int'(phy_ref), 0);

    // R7/R1: delay field untouched by this mask keeps its reset value 1
    cfg_write(cfg_word(0, 4, 0, 1, 1), M_SEL | M_DIV | M_GATE | M_PHY);
    repeat (60) @(negedge clk);
    measure_phase(ph);
    check("R7 default delay", ph, 1);

    for (int d = 0; d < 4; d++) begin
      cfg_write(cfg_word(0, 0, d, 0, 0), M_DLY);
      repeat (40) @(negedge clk);
      measure_phase(ph);
      check($sformatf("R7 delay %0d", d), ph, d);
    end

    // main vector walk, delay 0
    for (int i = 0; i < 10; i++) begin
      p0 = VEC[i][0]; p1 = VEC[i][1];
      cfg_write(cfg_word(VEC[i][2], VEC[i][3], 0, 1, 1), M_ALL);
      repeat (80) @(negedge clk);
      measure(hi, lo);
      tag = (VEC[i][2] == 1) ? "R2" : ((VEC[i][3] < 2) ? "R4" : "R3");
      check($sformatf("%s vec %0d high", tag, i), hi, VEC[i][4]);
      check($sformatf("R5 vec %0d low", i), lo, VEC[i][4]);
    end

    // R1: all-ones data under a select-only mask changes just the select
    p0 = 1; p1 = 3;
    cfg_write(cfg_word(0, 2, 0, 1, 1), M_ALL);
    repeat (60) @(negedge clk);
    cfg_write(M_ALL, M_SEL);
    repeat (60) @(negedge clk);
    measure(hi, lo);
    check("R1 masked write", hi, 6);

    // R6: gate off, reference output keeps running
    cfg_write(cfg_word(0, 0, 0, 0, 0), M_GATE);
    repeat (10) @(negedge clk);
    count_highs(48, ntx, nphy);
    check("R6 gated tx highs", ntx, 0);
    check("R6 phy still toggles", int'(nphy > 0), 1);
    cfg_write(M_GATE, M_GATE);

    // R8: phy output off, tx keeps running
    cfg_write(cfg_word(0, 0, 0, 0, 0), M_PHY);
    repeat (10) @(negedge clk);
    count_highs(48, ntx, nphy);
    check("R8 phy off highs", nphy, 0);
    check("R8 tx still toggles", int'(ntx > 0), 1);
    cfg_write(M_PHY, M_PHY);

    // R9: ratio change written during a high phase
    p0 = 1; p1 = 3;
    cfg_write(cfg_word(0, 7, 0, 1, 1), M_ALL);
    repeat (80) @(negedge clk);
    guard = 0;
    while (tx_clk !== 1'b0 && guard < GUARD) begin @(negedge clk); guard++; end
    while (tx_clk !== 1'b1 && guard < GUARD) begin @(negedge clk); guard++; end
    cfg_we = 1'b1; cfg_wdata = cfg_word(0, 2, 0, 1, 1); cfg_wmask = M_ALL;
    hi = 0;
    while (tx_clk === 1'b1 && guard < GUARD) begin
      hi++; @(negedge clk); cfg_we = 1'b0; guard++;
    end
    cfg_we = 1'b0;
    check("R9 high phase kept", hi, 7);
    repeat (40) @(negedge clk);
    measure(hi, lo);
    check("R9 new ratio", hi, 2);

    // R10: reset while running
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    check("R10 tx after reset", int'(tx_clk), 0);
    check("R10 phy after reset", int'(phy_ref), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (30) @(negedge clk);
    check("R1 config restored", int'(tx_clk) + int'(phy_ref), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule